// File: doc/BRIEF.md
# Multicast Address Hash Filter

This block sits on the receive side of an Ethernet port. For each frame it decides whether to accept or drop it, and it makes that decision from the destination address alone. The six destination bytes arrive one per cycle on a byte bus. A valid strobe qualifies each byte, and a start marker flags the first one. While the bytes arrive, the block builds a CRC-32 over them. When the sixth byte has been taken, it folds the CRC into a table index and looks up a software-loaded multicast hash table. It then produces a registered accept/drop verdict with a one-cycle valid pulse.

The table holds 64, 128 or 256 bits, chosen at build time. It is stored as 32-bit words behind a simple register port, next to a control register and a read-only capability register. The control register holds three modes:
- accept everything;
- accept every multicast frame;
- accept a multicast frame only if its hashed table bit is set.

Unicast perfect matching is done elsewhere, and its result enters on one input pin. Software writes land in a shadow copy at any time. They reach the copy that judges frames only while no address is being received.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, the control register (offset 0x08) and every table word read 0. Only broadcast frames and unicast frames with `ucast_match` high are then accepted.
- R2: The hash index works as follows.
  - Compute a reflected CRC-32 (polynomial 0xEDB88320, preset all ones) over the six address bytes, first byte first and each byte LSB first.
  - Complement the CRC, then reverse all 32 bits.
  - The index is the top log2(N) bits of the result.
  - Table word i sits at offset 0x10+4*i. It holds index values 32*i to 32*i+31, with index bits [4:0] giving the bit position inside the word.
  - With control bit 2 set (hash enable), a multicast frame is accepted exactly when its table bit is 1.
- R3: With control bit 0 set (promiscuous), every frame is accepted.
- R4: With control bit 1 set (pass all multicast), every multicast frame is accepted whatever the table holds. Unicast handling is unchanged.
- R5: A frame is multicast when bit 0 of its first address byte is 1. With control bits 1 and 2 both clear, a non-broadcast multicast frame is dropped.
- R6: The broadcast address FF:FF:FF:FF:FF:FF is always accepted.
- R7: A unicast frame is accepted exactly when `ucast_match`, sampled with the sixth byte, is high, unless promiscuous mode is on.
- R8: `dec_valid` is high for exactly one cycle per frame, in the cycle right after the sixth byte is taken. `dec_accept` holds the verdict in that cycle.
- R9: The register at offset 0x04 reads the table size code in bits 25:24 (1 = 64, 2 = 128, 3 = 256 bits) and zeros elsewhere. Writes to it are ignored.
- R10: A register write made while a frame's address is being received does not affect that frame. It does apply to a frame that starts at least one idle cycle after the first frame ends.
- R11: `reg_rdata` shows, one cycle after `reg_addr` is presented, the last value written to the control register or table word at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| da_valid | input | 1 | Address byte valid |
| da_sof | input | 1 | Marks the first address byte of a frame |
| da_byte | input | 8 | Destination address byte |
| ucast_match | input | 1 | Unicast perfect-match result from outside |
| dec_valid | output | 1 | Verdict valid pulse |
| dec_accept | output | 1 | 1 = accept frame, 0 = drop |

## Verification
The bench runs a 128-bit table, so the index has seven bits and selects among four words. A wrong word select, a wrong bit order in the reversal, or an uncomplemented CRC would mark the wrong bit, and the bench's own CRC model would catch the mismatched verdict. Each verdict is also checked against the exact cycle after the sixth byte, which exposes an extra or missing pipeline register. A control write made in the middle of an address must leave that frame judged by the old mode and switch the next one. A design without shadowing would accept the frame early. Writing to the capability register and watching its readback stay unchanged covers the read-only path.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam logic [7:0] OFS_CAP = 8'h04;
  localparam logic [7:0] OFS_CTL = 8'h08;
  localparam logic [7:0] OFS_TBL = 8'h10;

  // control register layout: bit2 hash_en, bit1 pass_mc, bit0 promisc
  typedef struct packed {
    logic hash_en;
    logic pass_mc;
    logic promisc;
  } ctl_t;

  // one byte of reflected CRC-32, LSB of the byte first
  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/mhf_crc_acc.sv
module mhf_crc_acc #(
  parameter int ADDR_BYTES = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        da_valid,
  input  logic        da_sof,
  input  logic [7:0]  da_byte,
  output logic        busy,
  output logic        done,
  output logic [31:0] crc_final,
  output logic        is_mcast,
  output logic        is_bcast
);
  import mhf_pkg::*;
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);

  logic             in_frame;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      crc;
  logic             mc_r, bc_r;
  logic             take;

  assign take      = da_valid && (da_sof || in_frame);
  assign crc_final = crc_byte(da_sof ? 32'hFFFF_FFFF : crc, da_byte);
  assign done      = da_valid && !da_sof && in_frame && (cnt == CNT_W'(ADDR_BYTES - 1));
  assign busy      = in_frame || (da_valid && da_sof);
  assign is_mcast  = mc_r;
  assign is_bcast  = bc_r && (&da_byte);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      cnt      <= '0;
      crc      <= '1;
      mc_r     <= 1'b0;
      bc_r     <= 1'b0;
    end else if (take) begin
      crc <= crc_final;
      if (da_sof) begin
        in_frame <= 1'b1;
        cnt      <= CNT_W'(1);
        mc_r     <= da_byte[0];
        bc_r     <= &da_byte;
      end else begin
        cnt  <= cnt + CNT_W'(1);
        bc_r <= bc_r && (&da_byte);
        if (done) in_frame <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mhf_cfg_regs.sv
module mhf_cfg_regs #(
  parameter int TBL_BITS = 64,
  parameter int AW       = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic [AW-1:0]       reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                busy,
  output mhf_pkg::ctl_t       act_ctl,
  output logic [TBL_BITS-1:0] act_tbl
);
  import mhf_pkg::*;
  localparam int WORDS = TBL_BITS / 32;
  localparam int IDX_W = $clog2(TBL_BITS);
  localparam logic [1:0] CAP_CODE = 2'(IDX_W - 5);

  ctl_t                   sh_ctl;
  logic [WORDS-1:0][31:0] sh_words;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_ctl   <= '0;
      sh_words <= '0;
    end else if (reg_wr) begin
      if (reg_addr == AW'(OFS_CTL)) sh_ctl <= ctl_t'(reg_wdata[2:0]);
      for (int w = 0; w < WORDS; w++)
        if (reg_addr == AW'(OFS_TBL) + AW'(4 * w)) sh_words[w] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_ctl <= '0;
      act_tbl <= '0;
    end else if (!busy) begin
      act_ctl <= sh_ctl;
      act_tbl <= sh_words;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      reg_rdata <= '0;
      if (reg_addr == AW'(OFS_CAP)) reg_rdata <= {6'd0, CAP_CODE, 24'd0};
      if (reg_addr == AW'(OFS_CTL)) reg_rdata <= {29'd0, sh_ctl};
      for (int w = 0; w < WORDS; w++)
        if (reg_addr == AW'(OFS_TBL) + AW'(4 * w)) reg_rdata <= sh_words[w];
    end
  end

  // R10
  act_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(act_ctl) && $stable(act_tbl)));
endmodule

// File: rtl/mhf_decide.sv
module mhf_decide #(
  parameter int TBL_BITS = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                done,
  input  logic [31:0]         crc_final,
  input  logic                is_mcast,
  input  logic                is_bcast,
  input  logic                ucast_match,
  input  mhf_pkg::ctl_t       act_ctl,
  input  logic [TBL_BITS-1:0] act_tbl,
  output logic                dec_valid,
  output logic                dec_accept
);
  localparam int IDX_W = $clog2(TBL_BITS);

  logic [31:0]      rev;
  logic [IDX_W-1:0] idx;
  logic             hit, verdict;

  always_comb begin
    for (int k = 0; k < 32; k++) rev[k] = ~crc_final[31 - k];
  end
  assign idx = rev[31 -: IDX_W];
  assign hit = act_tbl[idx];
  assign verdict = is_bcast || act_ctl.promisc ||
                   (is_mcast ? (act_ctl.pass_mc || (act_ctl.hash_en && hit)) : ucast_match);

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid <= done;
      if (done) dec_accept <= verdict;
    end
  end

  // R3
  promisc_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (done && act_ctl.promisc) |=> (dec_valid && dec_accept));
  // R6
  bcast_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (done && is_bcast) |=> dec_accept);
  // R4
  pass_mc_chk: assert property (@(posedge clk) disable iff (rst)
    (done && is_mcast && act_ctl.pass_mc) |=> dec_accept);
  // R7
  ucast_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !is_mcast && !act_ctl.promisc && !ucast_match) |=> !dec_accept);
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int TBL_BITS   = 64,
  parameter int ADDR_BYTES = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        da_valid,
  input  logic        da_sof,
  input  logic [7:0]  da_byte,
  input  logic        ucast_match,
  output logic        dec_valid,
  output logic        dec_accept
);
  import mhf_pkg::*;

  logic                busy, done, is_mcast, is_bcast;
  logic [31:0]         crc_final;
  ctl_t                act_ctl;
  logic [TBL_BITS-1:0] act_tbl;

  mhf_crc_acc #(.ADDR_BYTES(ADDR_BYTES)) u_crc (
    .clk(clk), .rst(rst), .da_valid(da_valid), .da_sof(da_sof), .da_byte(da_byte),
    .busy(busy), .done(done), .crc_final(crc_final),
    .is_mcast(is_mcast), .is_bcast(is_bcast));

  mhf_cfg_regs #(.TBL_BITS(TBL_BITS), .AW(8)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .act_ctl(act_ctl), .act_tbl(act_tbl));

  mhf_decide #(.TBL_BITS(TBL_BITS)) u_dec (
    .clk(clk), .rst(rst), .done(done), .crc_final(crc_final),
    .is_mcast(is_mcast), .is_bcast(is_bcast), .ucast_match(ucast_match),
    .act_ctl(act_ctl), .act_tbl(act_tbl),
    .dec_valid(dec_valid), .dec_accept(dec_accept));

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);
endmodule

// File: tb/mcast_hash_filter_bench.sv
module mcast_hash_filter_bench;
  localparam int TBL   = 128;
  localparam int WORDS = TBL / 32;
  localparam int IDXW  = $clog2(TBL);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        da_valid = 1'b0, da_sof = 1'b0, ucast_match = 1'b0;
  logic [7:0]  da_byte = '0;
  logic        dec_valid, dec_accept;

  int checks = 0, fails = 0;
  int cyc = 0;
  bit done_flag = 0;

  logic       exp_acc[$];
  int         exp_cyc[$];
  string      exp_tag[$];

  logic [2:0]     m_ctl;
  logic [TBL-1:0] m_tbl;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mcast_hash_filter #(.TBL_BITS(TBL)) u_mcast_hash_filter (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .da_valid(da_valid), .da_sof(da_sof), .da_byte(da_byte),
    .ucast_match(ucast_match), .dec_valid(dec_valid), .dec_accept(dec_accept));

  function automatic logic [IDXW-1:0] ref_idx(input logic [47:0] da);
    logic [31:0] c;
    logic [7:0]  b;
    logic        fb;
    logic [IDXW-1:0] ix;
    c = 32'hFFFF_FFFF;
    for (int j = 0; j < 6; j++) begin
      b = da[47 - 8*j -: 8];
      for (int q = 0; q < 8; q++) begin
        fb = c[0] ^ b[q];
        c  = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    for (int k = 0; k < IDXW; k++) ix[IDXW-1-k] = ~c[k];
    return ix;
  endfunction

  function automatic logic ref_accept(input logic [47:0] da, input logic um);
    logic bc, mc;
    bc = (da == 48'hFFFF_FFFF_FFFF);
    mc = da[40];
    return bc || m_ctl[0] || (mc ? (m_ctl[1] || (m_ctl[2] && m_tbl[ref_idx(da)])) : um);
  endfunction

  function automatic void model_write(input logic [7:0] a, input logic [31:0] d);
    if (a == 8'h08) m_ctl = d[2:0];
    for (int w = 0; w < WORDS; w++)
      if (a == 8'(8'h10 + 4*w)) m_tbl[32*w +: 32] = d;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    check(tag, reg_rdata, exp);
  endtask

  task automatic frame(input string tag, input logic [47:0] da, input logic um,
                       input bit mid, input logic [7:0] ma, input logic [31:0] md);
    logic e;
    e = ref_accept(da, um);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      da_valid = 1'b1; da_sof = (i == 0); da_byte = da[47 - 8*i -: 8]; ucast_match = um;
      reg_wr = 1'b0;
      if (mid && i == 2) begin reg_wr = 1'b1; reg_addr = ma; reg_wdata = md; end
      if (i == 5) begin
        exp_acc.push_back(e); exp_cyc.push_back(cyc + 1); exp_tag.push_back(tag);
      end
    end
    @(negedge clk);
    da_valid = 1'b0; da_sof = 1'b0; reg_wr = 1'b0; ucast_match = 1'b0;
    if (mid) model_write(ma, md);
  endtask

  always @(negedge clk) begin
    if (!rst && dec_valid) begin
      if (exp_acc.size() == 0) begin
        checks++; fails++;
        $display("FAIL R8 unexpected verdict actual=1 expected=0");
      end else begin
        automatic logic  ea = exp_acc.pop_front();
        automatic int    ec = exp_cyc.pop_front();
        automatic string et = exp_tag.pop_front();
        check({et, " verdict"}, {31'd0, dec_accept}, {31'd0, ea});
        check({"R8 timing of ", et}, ec, cyc);
      end
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  localparam logic [47:0] A1 = 48'h01005E000001;
  localparam logic [47:0] A2 = 48'h01005E7F1234;
  localparam logic [47:0] A3 = 48'h3333000000FB;
  localparam logic [47:0] UC = 48'h001122334455;
  localparam logic [47:0] BC = 48'hFFFFFFFFFFFF;

  initial begin
    logic [IDXW-1:0] ix;
    m_ctl = '0; m_tbl = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 dec_valid after reset", {31'd0, dec_valid}, 32'd0);
    rd_check("R9 capability code", 8'h04, 32'h0200_0000);
    rd_check("R1 control reset", 8'h08, 32'd0);
    for (int w = 0; w < WORDS; w++) rd_check("R1 table reset", 8'(8'h10 + 4*w), 32'd0);

    frame("R1 multicast after reset", A1, 1'b0, 0, 8'h0, 32'h0);
    frame("R6 broadcast", BC, 1'b0, 0, 8'h0, 32'h0);
    frame("R7 unicast match", UC, 1'b1, 0, 8'h0, 32'h0);
    frame("R7 unicast no match", UC, 1'b0, 0, 8'h0, 32'h0);

    wr(8'h08, 32'h4);
    ix = ref_idx(A1);
    wr(8'(8'h10 + 4*(ix >> 5)), 32'h1 << ix[4:0]);
    rd_check("R11 table readback", 8'(8'h10 + 4*(ix >> 5)), 32'h1 << ix[4:0]);
    rd_check("R11 control readback", 8'h08, 32'h4);
    frame("R2 hashed hit", A1, 1'b0, 0, 8'h0, 32'h0);
    frame("R2 other address", A2, 1'b0, 0, 8'h0, 32'h0);
    frame("R2 third address", A3, 1'b0, 0, 8'h0, 32'h0);
    frame("R7 unicast with hash on", UC, 1'b0, 0, 8'h0, 32'h0);
    for (int w = 0; w < WORDS; w++) wr(8'(8'h10 + 4*w), 32'hFFFF_FFFF);
    frame("R2 full table", A2, 1'b0, 0, 8'h0, 32'h0);
    for (int w = 0; w < WORDS; w++) wr(8'(8'h10 + 4*w), ~(32'h1 << ix[4:0]));
    frame("R2 only own bit clear", A1, 1'b0, 0, 8'h0, 32'h0);
    frame("R2 others set", A3, 1'b0, 0, 8'h0, 32'h0);

    wr(8'h08, 32'h0);
    frame("R5 multicast no mode", A2, 1'b0, 0, 8'h0, 32'h0);
    wr(8'h08, 32'h2);
    frame("R4 pass all mc A1", A1, 1'b0, 0, 8'h0, 32'h0);
    frame("R4 pass all mc A2", A2, 1'b0, 0, 8'h0, 32'h0);
    frame("R4 unicast unaffected", UC, 1'b0, 0, 8'h0, 32'h0);
    wr(8'h08, 32'h1);
    frame("R3 promisc unicast", UC, 1'b0, 0, 8'h0, 32'h0);
    frame("R3 promisc multicast", A1, 1'b0, 0, 8'h0, 32'h0);

    wr(8'h04, 32'hFFFF_FFFF);
    rd_check("R9 capability read-only", 8'h04, 32'h0200_0000);

    wr(8'h08, 32'h0);
    frame("R10 mid-frame write ignored", UC, 1'b0, 1, 8'h08, 32'h1);
    frame("R10 write applied next frame", UC, 1'b0, 0, 8'h0, 32'h0);
    frame("R8 back to back", A2, 1'b0, 0, 8'h0, 32'h0);

    repeat (4) @(negedge clk);
    check("R8 all verdicts seen", exp_acc.size(), 0);
    finish_run();
  end
endmodule